// File: doc/BRIEF.md
# Add/Subtract Status Flag Unit

This block performs an add or subtract on two operands, either in byte or word width, and derives the six arithmetic status bits from that operation: carry (or borrow), parity, half-carry out of the low nibble, zero, sign and signed overflow. The result and the six status bits are combinational outputs, so a surrounding datapath can use them in the same cycle.

The block also holds a 16-bit status word. When an operation is marked valid, its six arithmetic bits are captured into the word. Three control bits share the word: single-step, interrupt enable and direction. Only an explicit write of the whole word changes them; arithmetic never does. Bits with no assigned meaning always read as zero.

Top module: `arith_flag_unit`

## Requirements
- R1: `result` is `opa` plus `opb` for ADD (op_sel=0), that sum plus `carry_in` for ADC (1), `opa` minus `opb` for SUB (2), and that difference minus `carry_in` for SBB (3), all modulo 2^width. Width is 16 bits when `word_mode`=1 and 8 bits when it is 0. In byte mode, `result[15:8]` is zero and the upper operand bytes are ignored. ADD and SUB ignore `carry_in`.
- R2: `cf_o` is 1 when an add produces a carry out of the top bit of the selected width. For a subtract, `cf_o` is 1 when a borrow into that bit is needed, which means the true difference is negative.
- R3: `af_o` is 1 on a carry out of bit 3 for an add. For a subtract, it is 1 when the low-nibble difference, including the borrow-in, is negative.
- R4: `pf_o` is 1 when `result[7:0]` holds an even number of ones, in both byte and word mode.
- R5: `zf_o` is 1 exactly when the result at the selected width is zero.
- R6: `sf_o` equals bit 7 of the result in byte mode and bit 15 in word mode.
- R7: `of_o` is 1 when the two's-complement result lies outside the signed range of the selected width.
- R8: When `op_valid`=1 and `flags_wr`=0 at a clock edge, `flags_q` takes the six arithmetic bits at positions carry=0, parity=2, half-carry=4, zero=6, sign=7 and overflow=11.
- R9: When `flags_wr`=1 at a clock edge, `flags_q` becomes `flags_wdata & 16'h0FD5`. This covers the six bit positions of R8 plus single-step=8, interrupt enable=9 and direction=10. A write takes priority over `op_valid` in the same cycle. Bits 1, 3, 5 and 12 to 15 always read as zero.
- R10: While `rst_n` is low, and for the clock edges until its synchronous release takes effect, `flags_q` is zero.
- R11: Bits 8 to 10 of `flags_q` never change without `flags_wr`. This holds whether or not an arithmetic update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Operation: 0 ADD, 1 ADC, 2 SUB, 3 SBB |
| word_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opa | input | 16 | First operand (minuend for subtract) |
| opb | input | 16 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Incoming carry/borrow used by ADC and SBB |
| op_valid | input | 1 | Capture the arithmetic status into `flags_q` |
| flags_wr | input | 1 | Load the whole status word from `flags_wdata` |
| flags_wdata | input | 16 | Status word write data |
| result | output | 16 | Arithmetic result, zero-extended in byte mode |
| cf_o | output | 1 | Carry / borrow |
| pf_o | output | 1 | Even parity of result low byte |
| af_o | output | 1 | Nibble carry / borrow |
| zf_o | output | 1 | Result is zero |
| sf_o | output | 1 | Result sign |
| of_o | output | 1 | Signed overflow |
| flags_q | output | 16 | Registered status word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit narrow width and a 4-bit nibble. The narrow width is small enough to sweep every byte operand pair under all four operations, so every carry, borrow, half-carry, parity and overflow combination in byte mode is reached. Word mode is covered by a strided sweep that includes the signed boundary values 0x7FFF, 0x8000, 0x0000 and 0xFFFF. Register behaviour is checked by directed sequences: write priority, arithmetic capture that keeps the control bits, and reset both at start-up and in the middle of a run.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBB = 2'd3
  } arith_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic hcy;
    logic par;
    logic cry;
  } stat_flags_t;

  localparam int STAT_W   = 16;
  localparam int POS_CRY  = 0;
  localparam int POS_PAR  = 2;
  localparam int POS_HCY  = 4;
  localparam int POS_ZRO  = 6;
  localparam int POS_SGN  = 7;
  localparam int POS_STEP = 8;
  localparam int POS_IEN  = 9;
  localparam int POS_DIR  = 10;
  localparam int POS_OVF  = 11;

  localparam logic [STAT_W-1:0] DEFINED_MASK = 16'h0FD5;
  localparam logic [STAT_W-1:0] CTRL_MASK    = 16'h0700;

endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIB_W    = 4
) (
  input  logic [WIDE_W-1:0] a_in,
  input  logic [WIDE_W-1:0] b_in,
  input  logic              cy_in,
  input  logic              subtract,
  input  logic              narrow,
  output logic [WIDE_W-1:0] sum_out,
  output logic              cy_out_msb,
  output logic              cy_into_msb,
  output logic              cy_nib
);
  localparam int UPPER_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] b_eff;
  logic [WIDE_W:0]   chain;
  logic [WIDE_W-1:0] raw_sum;

  // Subtract is done as a + ~b + ~borrow; the chain carries "no borrow".
  assign b_eff    = subtract ? ~b_in : b_in;
  assign chain[0] = subtract ? ~cy_in : cy_in;

  genvar i;
  generate
    for (i = 0; i < WIDE_W; i++) begin : g_bit
      logic prop;
      assign prop         = a_in[i] ^ b_eff[i];
      assign raw_sum[i]   = prop ^ chain[i];
      assign chain[i+1]   = (a_in[i] & b_eff[i]) | (prop & chain[i]);
    end
  endgenerate

  always_comb begin
    if (narrow) begin
      sum_out     = {{UPPER_W{1'b0}}, raw_sum[NARROW_W-1:0]};
      cy_out_msb  = chain[NARROW_W];
      cy_into_msb = chain[NARROW_W-1];
    end else begin
      sum_out     = raw_sum;
      cy_out_msb  = chain[WIDE_W];
      cy_into_msb = chain[WIDE_W-1];
    end
  end

  assign cy_nib = chain[NIB_W];
endmodule

// File: rtl/status_eval.sv
module status_eval
  import arith_flag_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [WIDE_W-1:0] sum_in,
  input  logic              cy_out_msb,
  input  logic              cy_into_msb,
  input  logic              cy_nib,
  input  logic              subtract,
  input  logic              narrow,
  output stat_flags_t       stat
);
  always_comb begin
    stat.cry = subtract ^ cy_out_msb;
    stat.hcy = subtract ^ cy_nib;
    stat.ovf = cy_into_msb ^ cy_out_msb;
    stat.par = ~^sum_in[NARROW_W-1:0];
    if (narrow) begin
      stat.zro = (sum_in[NARROW_W-1:0] == '0);
      stat.sgn = sum_in[NARROW_W-1];
    end else begin
      stat.zro = (sum_in == '0);
      stat.sgn = sum_in[WIDE_W-1];
    end
  end
endmodule

// File: rtl/flag_word_reg.sv
module flag_word_reg
  import arith_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arith_load,
  input  stat_flags_t       stat,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] word_q
);
  logic [STAT_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    word_d  = word_q;
    word_en = wr_en | arith_load;
    if (wr_en) begin
      word_d = wr_data & DEFINED_MASK;
    end else if (arith_load) begin
      word_d[POS_CRY] = stat.cry;
      word_d[POS_PAR] = stat.par;
      word_d[POS_HCY] = stat.hcy;
      word_d[POS_ZRO] = stat.zro;
      word_d[POS_SGN] = stat.sgn;
      word_d[POS_OVF] = stat.ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import arith_flag_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIB_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic              word_mode,
  input  logic [WIDE_W-1:0] opa,
  input  logic [WIDE_W-1:0] opb,
  input  logic              carry_in,
  input  logic              op_valid,
  input  logic              flags_wr,
  input  logic [STAT_W-1:0] flags_wdata,
  output logic [WIDE_W-1:0] result,
  output logic              cf_o,
  output logic              pf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic [STAT_W-1:0] flags_q
);
  arith_op_e   op;
  logic        subtract;
  logic        use_cy;
  logic        cy_eff;
  logic        narrow;
  logic        c_out;
  logic        c_into;
  logic        c_nib;
  logic        rst_q_n;
  stat_flags_t stat;

  always_comb begin
    op       = arith_op_e'(op_sel);
    subtract = (op == OP_SUB) || (op == OP_SBB);
    use_cy   = (op == OP_ADC) || (op == OP_SBB);
    cy_eff   = use_cy & carry_in;
    narrow   = ~word_mode;
  end

  reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  addsub_chain #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .NIB_W(NIB_W)) u_chain (
    .a_in        (opa),
    .b_in        (opb),
    .cy_in       (cy_eff),
    .subtract    (subtract),
    .narrow      (narrow),
    .sum_out     (result),
    .cy_out_msb  (c_out),
    .cy_into_msb (c_into),
    .cy_nib      (c_nib)
  );

  status_eval #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_eval (
    .sum_in      (result),
    .cy_out_msb  (c_out),
    .cy_into_msb (c_into),
    .cy_nib      (c_nib),
    .subtract    (subtract),
    .narrow      (narrow),
    .stat        (stat)
  );

  flag_word_reg u_word (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .arith_load (op_valid),
    .stat       (stat),
    .wr_en      (flags_wr),
    .wr_data    (flags_wdata),
    .word_q     (flags_q)
  );

  assign cf_o = stat.cry;
  assign pf_o = stat.par;
  assign af_o = stat.hcy;
  assign zf_o = stat.zro;
  assign sf_o = stat.sgn;
  assign of_o = stat.ovf;
endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk
  import arith_flag_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              word_mode,
  input logic              op_valid,
  input logic              flags_wr,
  input logic [STAT_W-1:0] flags_wdata,
  input logic [WIDE_W-1:0] result,
  input logic              cf_o,
  input logic              pf_o,
  input logic              sf_o,
  input logic              of_o,
  input logic [STAT_W-1:0] flags_q
);
  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_q_n)
    flags_wr |=> flags_q == ($past(flags_wdata) & DEFINED_MASK));

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flags_q & ~DEFINED_MASK) == '0);

  a_r11_ctl_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !flags_wr |=> (flags_q & CTRL_MASK) == ($past(flags_q) & CTRL_MASK));

  a_r8_arith_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && !flags_wr) |=>
      (flags_q[POS_CRY] == $past(cf_o)) && (flags_q[POS_OVF] == $past(of_o)));

  a_r1_byte_upper: assert property (@(posedge clk) disable iff (!rst_q_n)
    !word_mode |-> result[WIDE_W-1:NARROW_W] == '0);

  a_r6_sign_bit: assert property (@(posedge clk) disable iff (!rst_q_n)
    sf_o == (word_mode ? result[WIDE_W-1] : result[NARROW_W-1]));

  a_r4_low_parity: assert property (@(posedge clk) disable iff (!rst_q_n)
    pf_o == ~^result[NARROW_W-1:0]);
endmodule

bind arith_flag_unit arith_flag_unit_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .word_mode   (word_mode),
  .op_valid    (op_valid),
  .flags_wr    (flags_wr),
  .flags_wdata (flags_wdata),
  .result      (result),
  .cf_o        (cf_o),
  .pf_o        (pf_o),
  .sf_o        (sf_o),
  .of_o        (of_o),
  .flags_q     (flags_q)
);

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  op_sel;
  logic        word_mode;
  logic [15:0] opa;
  logic [15:0] opb;
  logic        carry_in;
  logic        op_valid;
  logic        flags_wr;
  logic [15:0] flags_wdata;
  logic [15:0] result;
  logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;
  logic [15:0] flags_q;

  int checks;
  int failures;
  bit finished;

  arith_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .word_mode(word_mode),
    .opa(opa), .opb(opb), .carry_in(carry_in), .op_valid(op_valid),
    .flags_wr(flags_wr), .flags_wdata(flags_wdata), .result(result),
    .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o),
    .of_o(of_o), .flags_q(flags_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_val(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (op=%0d word=%0d a=0x%0h b=0x%0h c=%0d)",
               req, actual, expected, op_sel, word_mode, opa, opb, carry_in);
    end
  endtask

  // Reference model computed from the arithmetic definitions.
  task automatic check_vector(input int op, input int wm, input int a_in, input int b_in, input int c_in);
    int w, m, a, b, cc, r, res, sa, sb, sr, ones;
    bit sub;
    int e_cf, e_af, e_pf, e_zf, e_sf, e_of;
    op_sel    = op[1:0];
    word_mode = wm[0];
    opa       = a_in[15:0];
    opb       = b_in[15:0];
    carry_in  = c_in[0];
    #1;
    w   = wm ? 16 : 8;
    m   = (1 << w) - 1;
    a   = a_in & m;
    b   = b_in & m;
    cc  = (op == 1 || op == 3) ? (c_in & 1) : 0;
    sub = (op >= 2);
    sa  = (a >= (1 << (w-1))) ? a - (1 << w) : a;
    sb  = (b >= (1 << (w-1))) ? b - (1 << w) : b;
    if (!sub) begin
      r    = a + b + cc;
      e_cf = (r > m) ? 1 : 0;
      e_af = (((a & 15) + (b & 15) + cc) > 15) ? 1 : 0;
      sr   = sa + sb + cc;
    end else begin
      r    = a - b - cc;
      e_cf = (r < 0) ? 1 : 0;
      e_af = (((a & 15) - (b & 15) - cc) < 0) ? 1 : 0;
      sr   = sa - sb - cc;
    end
    res  = r & m;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (res >> k) & 1;
    e_pf = (ones % 2 == 0) ? 1 : 0;
    e_zf = (res == 0) ? 1 : 0;
    e_sf = (res >> (w-1)) & 1;
    e_of = (sr > (1 << (w-1)) - 1 || sr < -(1 << (w-1))) ? 1 : 0;
    check_val("R1 result",   int'(result), res);
    check_val("R2 carry",    int'(cf_o), e_cf);
    check_val("R3 halfcy",   int'(af_o), e_af);
    check_val("R4 parity",   int'(pf_o), e_pf);
    check_val("R5 zero",     int'(zf_o), e_zf);
    check_val("R6 sign",     int'(sf_o), e_sf);
    check_val("R7 overflow", int'(of_o), e_of);
  endtask

  // Drive one register cycle at the falling edge, sample at the next falling edge.
  task automatic reg_cycle(input int op, input int wm, input int a, input int b,
                           input bit valid, input bit wr, input int wdata);
    @(negedge clk);
    op_sel = op[1:0]; word_mode = wm[0]; opa = a[15:0]; opb = b[15:0];
    carry_in = 1'b0; op_valid = valid; flags_wr = wr; flags_wdata = wdata[15:0];
    @(negedge clk);
    op_valid = 1'b0; flags_wr = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    rst_n = 1'b0; op_sel = 2'd0; word_mode = 1'b0; opa = '0; opb = '0;
    carry_in = 1'b0; op_valid = 1'b0; flags_wr = 1'b0; flags_wdata = '0;
    repeat (3) @(negedge clk);
    check_val("R10 in reset", int'(flags_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_val("R10 after release", int'(flags_q), 0);

    // Byte mode: every operand pair under all four operations.
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          check_vector(op, 0, a | ((b * 7 & 255) << 8), b | (a << 8), (a ^ b) & 1);

    // Word mode: strided sweep plus signed boundaries.
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 1500; i++)
        check_vector(op, 1, (i * 40503 + 17) & 16'hFFFF, (i * 9973 + 3) & 16'hFFFF, i & 1);
      check_vector(op, 1, 16'h7FFF, 16'h0001, 1);
      check_vector(op, 1, 16'h8000, 16'h0001, 1);
      check_vector(op, 1, 16'hFFFF, 16'hFFFF, 1);
      check_vector(op, 1, 16'h0000, 16'h0000, 0);
      check_vector(op, 1, 16'h0000, 16'hFFFF, 1);
    end

    // R9: full write keeps only defined bits.
    reg_cycle(0, 0, 0, 0, 1'b0, 1'b1, 16'hFFFF);
    check_val("R9 write mask", int'(flags_q), 16'h0FD5);
    // R8/R11: byte 0+0 -> zero and parity set, control bits kept.
    reg_cycle(0, 0, 0, 0, 1'b1, 1'b0, 0);
    check_val("R8 R11 add zero", int'(flags_q), 16'h0744);
    // R8/R11: byte 0-1 -> carry, halfcy, parity, sign.
    reg_cycle(2, 0, 0, 1, 1'b1, 1'b0, 0);
    check_val("R8 R11 sub borrow", int'(flags_q), 16'h0795);
    // R9: write wins over simultaneous arithmetic capture.
    reg_cycle(0, 1, 16'h7FFF, 1, 1'b1, 1'b1, 16'h0000);
    check_val("R9 write priority", int'(flags_q), 16'h0000);
    // R8: word 0x7FFF+1 -> overflow, sign, halfcy, parity.
    reg_cycle(0, 1, 16'h7FFF, 1, 1'b1, 1'b0, 0);
    check_val("R8 word overflow", int'(flags_q), 16'h0894);
    // R9: direction bit only.
    reg_cycle(0, 0, 0, 0, 1'b0, 1'b1, 16'h0400);
    check_val("R9 ctl write", int'(flags_q), 16'h0400);
    // R11: operands change without capture or write.
    reg_cycle(2, 1, 16'h1234, 16'h5678, 1'b0, 1'b0, 16'hFFFF);
    check_val("R11 idle hold", int'(flags_q), 16'h0400);
    // R11: arithmetic capture keeps direction bit.
    reg_cycle(3, 1, 16'h0000, 16'h0000, 1'b1, 1'b0, 0);
    check_val("R11 arith keeps ctl", int'(flags_q), 16'h0444);
    // R10: reset in mid-run clears the word.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_val("R10 mid-run reset", int'(flags_q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_val("R10 after second release", int'(flags_q), 0);

    finish_run();
  end
endmodule